// File: doc/BRIEF.md
# Dual-Function Parallel Handshake Unit

This block accepts one data word together with a level request line and evaluates two word functions on that word at the same time. Each function sits inside a small atomic worker that follows a load/done handshake. The wrapper turns a rising edge on the request line into a single start pulse. That pulse, together with the same input word, goes to both workers. The wrapper keeps each worker's answer in a private hold stage, which opens only in the cycle where that worker's done line goes from low to high.

The upper worker computes the word minus one and wraps modulo 2^W. The lower worker computes the square of the word, truncated to W bits. The wrapper's done line is the AND of the two workers' done lines. Its result bus places the upper worker's answer above the lower worker's. A start is allowed only while the wrapper's own done was high in the previous cycle. A caller raises the request line, waits until done reads high again, and then reads both answers from the result bus in that same cycle.

Top module: `par_pair_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, done_o reads 1 and result_o reads all zeros.
- R2: A request is recognised in a cycle where load_i is 1 and was 0 in the previous cycle. In that cycle done_o reads 0, and in the following cycle it reads 1 again.
- R3: In the cycle after a request, bits [2W-1:W] of result_o equal (data_i - 1) mod 2^W, where data_i is the value sampled in the request cycle.
- R4: In the cycle after a request, bits [W-1:0] of result_o equal (data_i * data_i) mod 2^W, where data_i is the value sampled in the request cycle.
- R5: Holding load_i at 1 for further cycles starts nothing new. done_o stays 1 and result_o keeps its value even when data_i changes.
- R6: If load_i is already 1 when reset is released, this is not a request. done_o stays 1 and result_o stays zero until load_i has gone low and risen again.
- R7: Between requests, result_o holds the last captured pair whatever data_i does.
- R8: A request with data_i = 0 gives all ones in the upper field and zero in the lower field.
- R9: A new request two cycles after the previous one (load_i low for one cycle between them) is served and replaces both fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Request level; its rising edge starts both workers |
| data_i | input | W | Operand word, sampled in the request cycle |
| done_o | output | 1 | High when both workers are idle |
| result_o | output | 2*W | {decrement answer, square answer} |

## Verification
The embedded properties assume that a caller never expects a second start while done_o is low. This holds by construction, because a new rising edge on load_i needs at least one low cycle, and each worker finishes in a single cycle. They also assume that data_i is settled in the request cycle. The bench drives load_i and data_i together at the falling clock edge, always holds load_i low for at least one full cycle between requests, and asserts reset with load_i both low and high.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [0:0] {
        FN_DEC = 1'b0,
        FN_SQR = 1'b1
    } fn_kind_e;

    function automatic logic [63:0] fn_dec(input logic [63:0] a, input int unsigned w);
        logic [63:0] r;
        r = a - 64'd1;
        return r & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] fn_sqr(input logic [63:0] a, input int unsigned w);
        logic [63:0] r;
        r = a * a;
        return r & ((64'd1 << w) - 64'd1);
    endfunction

endpackage

// File: rtl/edge_pulse.sv
module edge_pulse #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= INIT;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/atom_unit.sv
module atom_unit
    import pair_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter fn_kind_e    KIND = FN_DEC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] arg_i,
    output logic         idle_o,
    output logic [W-1:0] res_o
);
    logic         go_edge;
    logic [W-1:0] comb_res;
    logic [63:0]  arg_wide;

    assign arg_wide = 64'(arg_i);

    edge_pulse #(.INIT(1'b1)) u_go_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (go_i),
        .rise_o (go_edge)
    );

    generate
        if (KIND == FN_DEC) begin : g_dec
            assign comb_res = W'(fn_dec(arg_wide, W));
        end else begin : g_sqr
            assign comb_res = W'(fn_sqr(arg_wide, W));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= comb_res;
    end

    assign idle_o = ~go_edge;

    // R2: a worker is busy for exactly one cycle
    assert_worker_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        !idle_o |=> idle_o);

endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         done_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic         open_now;
    logic [W-1:0] held_q;

    edge_pulse #(.INIT(1'b1)) u_done_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (done_i),
        .rise_o (open_now)
    );

    assign q_o = open_now ? d_i : held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= q_o;
    end

    // R7: without a rising done the captured value cannot move
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (done_i && $past(done_i)) |-> $stable(q_o));

endmodule

// File: rtl/par_pair_unit.sv
module par_pair_unit
    import pair_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [W-1:0]   data_i,
    output logic           done_o,
    output logic [2*W-1:0] result_o
);
    localparam int unsigned RW = 2 * W;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } pair_t;

    logic         req;
    logic         done_q;
    logic         start;
    logic         idle_hi, idle_lo;
    logic [W-1:0] raw_hi, raw_lo;
    pair_t        pair;

    edge_pulse #(.INIT(1'b1)) u_req_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (load_i),
        .rise_o (req)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b1;
        else     done_q <= done_o;
    end

    assign start = req & done_q;

    atom_unit #(.W(W), .KIND(FN_DEC)) u_hi (
        .clk    (clk),
        .rst    (rst),
        .go_i   (start),
        .arg_i  (data_i),
        .idle_o (idle_hi),
        .res_o  (raw_hi)
    );

    atom_unit #(.W(W), .KIND(FN_SQR)) u_lo (
        .clk    (clk),
        .rst    (rst),
        .go_i   (start),
        .arg_i  (data_i),
        .idle_o (idle_lo),
        .res_o  (raw_lo)
    );

    cap_hold #(.W(W)) u_cap_hi (
        .clk    (clk),
        .rst    (rst),
        .done_i (idle_hi),
        .d_i    (raw_hi),
        .q_o    (pair.hi)
    );

    cap_hold #(.W(W)) u_cap_lo (
        .clk    (clk),
        .rst    (rst),
        .done_i (idle_lo),
        .d_i    (raw_lo),
        .q_o    (pair.lo)
    );

    assign done_o   = idle_hi & idle_lo;
    assign result_o = RW'(pair);

    // R2: a start only follows a low level on load_i
    assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        start |-> (load_i && !$past(load_i)));

    // R2: busy lasts one cycle
    assert_done_returns_R2: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> done_o);

    // R3: upper field carries the decrement of the request word
    assert_hi_value_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |=> (result_o[RW-1:W] == W'($past(data_i) - W'(1))));

    // R4: lower field carries the square of the request word
    assert_lo_value_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |=> (result_o[W-1:0] == W'($past(data_i) * $past(data_i))));

endmodule

// File: tb/par_pair_unit_tb.sv
module par_pair_unit_tb_top;
    localparam int unsigned W        = 16;
    localparam time         CLK_PER  = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           load_i;
    logic [W-1:0]   data_i;
    logic           done_o;
    logic [2*W-1:0] result_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    par_pair_unit #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .data_i   (data_i),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic logic [W-1:0] ref_dec(input logic [W-1:0] a);
        return a - W'(1);
    endfunction

    function automatic logic [W-1:0] ref_sqr(input logic [W-1:0] a);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, a} * {{W{1'b0}}, a};
        return p[W-1:0];
    endfunction

    task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic ld);
        @(negedge clk);
        rst = 1'b1; load_i = ld; data_i = '0;
        repeat (3) @(negedge clk);
        check("R1 done during reset", {31'b0, done_o}, 32'd1);
        check("R1 result during reset", result_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", {31'b0, done_o}, 32'd1);
        check("R1 result after reset", result_o, '0);
    endtask

    // one request; load_i is low on entry and low on exit
    task automatic do_request(input logic [W-1:0] x, input string tag);
        @(negedge clk);
        load_i = 1'b1; data_i = x;
        #1;
        check({tag, " R2 busy in request cycle"}, {31'b0, done_o}, 32'd0);
        @(negedge clk);
        load_i = 1'b0; data_i = ~x;
        #1;
        check({tag, " R2 done next cycle"}, {31'b0, done_o}, 32'd1);
        check({tag, " R3 upper field"}, {16'b0, result_o[2*W-1:W]}, {16'b0, ref_dec(x)});
        check({tag, " R4 lower field"}, {16'b0, result_o[W-1:0]}, {16'b0, ref_sqr(x)});
    endtask

    task automatic t_reset_idle;
        do_reset(1'b0);
    endtask

    task automatic t_basic;
        do_request(16'd7, "basic7");
        do_request(16'h1234, "basic1234");
        do_request(16'hFFFF, "basicFFFF");
    endtask

    task automatic t_zero;
        do_request(16'd0, "zero");
        check("R8 all-ones upper", {16'b0, result_o[2*W-1:W]}, 32'h0000FFFF);
        check("R8 zero lower", {16'b0, result_o[W-1:0]}, 32'd0);
    endtask

    task automatic t_hold_level;
        logic [2*W-1:0] snap;
        do_request(16'd9, "hold");
        // raise again, then keep high while data changes
        @(negedge clk);
        load_i = 1'b1; data_i = 16'd21;
        @(negedge clk);
        snap = result_o;
        for (int i = 0; i < 4; i++) begin
            data_i = 16'(100 + i);
            @(negedge clk);
            check("R5 done while load held", {31'b0, done_o}, 32'd1);
            check("R5 result while load held", result_o, snap);
        end
        load_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_data;
        logic [2*W-1:0] snap;
        do_request(16'd300, "idle");
        snap = result_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            data_i = 16'(i * 977);
            #1;
            check("R7 result stable between requests", result_o, snap);
        end
    endtask

    task automatic t_load_at_reset;
        do_reset(1'b1);
        data_i = 16'd55;
        repeat (2) begin
            @(negedge clk);
            check("R6 no start from load high at reset", result_o, '0);
            check("R6 done stays high", {31'b0, done_o}, 32'd1);
        end
        load_i = 1'b0;
        do_request(16'd55, "after_reset_load");
    endtask

    task automatic t_back_to_back;
        do_request(16'd3, "b2b_first");
        do_request(16'd250, "b2b_second");
        check("R9 second request replaced pair", result_o,
              {ref_dec(16'd250), ref_sqr(16'd250)});
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_i = 1'b0; data_i = '0;
        t_reset_idle();
        t_basic();
        t_zero();
        t_hold_level();
        t_idle_data();
        t_back_to_back();
        t_load_at_reset();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule